// File: doc/BRIEF.md
# ADC Conversion Sequencer with Result Memory

This block drives an analog-to-digital converter through a programmed list of thirty-two conversion slots. Each slot has a control entry, which holds an input channel, a reference choice, a differential flag and a last-in-list flag. Each slot also has a result register and a "new result" flag. A host programs the entries, a start slot, a mode and an enable bit through a small register port. A trigger input then starts a run. The block requests one conversion at a time over a start/done handshake. It files each returned result in the slot that the conversion was made for.

A private slot pointer does the walking and cannot be read by the host. In the two single-slot modes, only the start slot is converted. In the two list modes, the pointer begins at the start slot and steps forward by one after every completed conversion. It wraps from slot 31 to slot 0. It stops after the first slot whose last-in-list flag is set. The one-shot modes clear the enable bit when their run ends, so the host must re-arm them. The repeating modes keep the enable bit set, and the next trigger runs the same work again. Clearing the enable bit during a list run lets the conversion in flight finish and then stops.

Top module: `adcseq_top`

## Requirements
- R1: After reset, busy and conv_start are low, every new-result flag is clear and the configuration word reads as zero.
- R2: Writing reg_addr 0..31 stores a control entry with channel in bits [4:0], reference in [6:5], differential in [7] and last-in-list in [8]. Each conversion presents that slot's channel, reference and differential values on conv_chan, conv_ref and conv_diff while conv_start is high.
- R3: Mode 0 (one-shot single) converts only the start slot, once per trigger, and then clears the enable bit. The configuration word at reg_addr 32 holds start slot in [4:0], mode in [6:5] and enable in [7].
- R4: Mode 1 (repeating single) converts the start slot once on each trigger and leaves the enable bit set.
- R5: Mode 2 (one-shot list) converts from the start slot upward, one slot per completed conversion. It ends after the first slot whose last-in-list flag is set, and then clears the enable bit.
- R6: In the list modes, the slot after 31 is slot 0.
- R7: Mode 3 (repeating list) runs the same list from the start slot again on every trigger and leaves the enable bit set.
- R8: A list with no last-in-list flag runs without end. Clearing the enable bit stops it after the conversion in progress, with no further conv_start.
- R9: Each completed conversion writes conv_result into its slot and sets that slot's new-result flag. A read of reg_addr 0..31 returns the flag in bit 15 and the result in bits [13:0], and clears the flag.
- R10: When a result is written to a slot in the same cycle that the host reads it, the read returns the previous contents and the flag stays set.
- R11: busy rises the cycle after an accepted trigger, stays high through every conversion of the run, and falls the cycle after the final conv_done.
- R12: A trigger while busy, or while the enable bit is clear, starts nothing and does not disturb the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears the flag of a result slot) |
| reg_addr | input | 6 | 0..31 slot entries/results, 32 configuration word |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| trig | input | 1 | Start request |
| busy | output | 1 | A run is in progress |
| new_flags | output | 32 | Per-slot new-result flags |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 5 | Channel of the current slot |
| conv_ref | output | 2 | Reference choice of the current slot |
| conv_diff | output | 1 | Differential flag of the current slot |
| conv_done | input | 1 | Converter finished, result valid |
| conv_result | input | 14 | Converter result |

## Verification
Two functions can land in the same cycle: the host read that clears a slot's new-result flag, and the converter's done pulse that writes a fresh result into the same slot. The bench's converter model raises conv_done and, in the same cycle, issues a read of the slot being written during a repeating single-slot run. It expects the earlier result with the flag still set. Two follow-up reads must then show the new result with the flag set, and then with the flag clear.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int NUM_SLOTS = 32;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int CH_W      = 5;
    localparam int REF_W     = 2;
    localparam int RES_W     = 14;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = SLOT_W + 1;

    typedef logic [SLOT_W-1:0] slot_t;

    typedef struct packed {
        logic             last;
        logic             diff;
        logic [REF_W-1:0] refsel;
        logic [CH_W-1:0]  chan;
    } slot_entry_t;

    typedef enum logic [1:0] {
        MODE_SINGLE     = 2'd0,
        MODE_REP_SINGLE = 2'd1,
        MODE_LIST       = 2'd2,
        MODE_REP_LIST   = 2'd3
    } run_mode_e;

    typedef struct packed {
        logic      enable;
        run_mode_e mode;
        slot_t     start;
    } run_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } walk_state_e;

    localparam int ENTRY_W = $bits(slot_entry_t);
    localparam int CFG_W   = $bits(run_cfg_t);

    function automatic logic mode_walks(run_mode_e m);
        return m[1];
    endfunction

    function automatic logic mode_repeats(run_mode_e m);
        return m[0];
    endfunction

endpackage

// File: rtl/adcseq_entry_mem.sv
module adcseq_entry_mem
    import adcseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  slot_t       wr_idx,
    input  slot_entry_t wr_entry,
    input  slot_t       rd_idx,
    output slot_entry_t rd_entry
);

    slot_entry_t entries_q [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                entries_q[i] <= '0;
            end
        end else if (wr_en) begin
            entries_q[wr_idx] <= wr_entry;
        end
    end

    assign rd_entry = entries_q[rd_idx];

endmodule

// File: rtl/adcseq_result_mem.sv
module adcseq_result_mem
    import adcseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  slot_t                wr_idx,
    input  logic [RES_W-1:0]     wr_res,
    input  logic                 rd_clr,
    input  slot_t                rd_idx,
    output logic [RES_W-1:0]     rd_res,
    output logic                 rd_flag,
    output logic [NUM_SLOTS-1:0] flags
);

    logic [RES_W-1:0]     res_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                res_q[i] <= '0;
            end
        end else if (wr_en) begin
            res_q[wr_idx] <= wr_res;
        end
    end

    // Per-slot flag: a result write outranks a clearing read of the same slot.
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flag
        logic set_c;
        logic clr_c;
        assign set_c = wr_en  && (wr_idx == slot_t'(g));
        assign clr_c = rd_clr && (rd_idx == slot_t'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[g] <= 1'b0;
            end else if (set_c) begin
                flags_q[g] <= 1'b1;
            end else if (clr_c) begin
                flags_q[g] <= 1'b0;
            end
        end
    end

    assign rd_res  = res_q[rd_idx];
    assign rd_flag = flags_q[rd_idx];
    assign flags   = flags_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> flags_q[$past(wr_idx)]); // R9

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !(wr_en && wr_idx == rd_idx)) |=> !flags_q[$past(rd_idx)]); // R9

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && wr_en && wr_idx == rd_idx) |=> flags_q[$past(rd_idx)]); // R10

endmodule

// File: rtl/adcseq_walker.sv
module adcseq_walker
    import adcseq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     trig,
    input  run_cfg_t cfg,
    input  logic     cur_last,
    input  logic     conv_done,
    output slot_t    ptr,
    output logic     conv_start,
    output logic     busy,
    output logic     res_we,
    output logic     clr_enable
);

    walk_state_e state_q;
    run_mode_e   mode_q;
    slot_t       start_q;
    slot_t       ptr_q;
    logic        done_ok;
    logic        final_c;

    assign done_ok    = (state_q == ST_WAIT) && conv_done;
    assign final_c    = !mode_walks(mode_q) || cur_last || !cfg.enable;
    assign res_we     = done_ok;
    assign clr_enable = done_ok && final_c && !mode_repeats(mode_q);
    assign conv_start = (state_q == ST_ISSUE);
    assign busy       = (state_q != ST_IDLE);
    assign ptr        = ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_SINGLE;
            start_q <= '0;
            ptr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (trig && cfg.enable) begin
                        mode_q  <= cfg.mode;
                        start_q <= cfg.start;
                        ptr_q   <= cfg.start;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (conv_done) begin
                        if (final_c) begin
                            state_q <= ST_IDLE;
                            ptr_q   <= start_q;
                        end else begin
                            ptr_q   <= ptr_q + 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_done) |=> busy); // R11

    AST_TRIG_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && trig && !conv_done) |=> $stable(ptr_q)); // R12

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        (done_ok && cur_last) |=> !busy); // R5

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done_ok && busy && ptr_q == slot_t'(NUM_SLOTS - 1) && mode_walks(mode_q)
         && !cur_last && cfg.enable) |=> (ptr_q == '0 && conv_start)); // R6

    AST_SINGLE_ONE: assert property (@(posedge clk) disable iff (rst)
        (done_ok && !mode_walks(mode_q)) |=> !busy); // R3

endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
    import adcseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic                 reg_re,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    input  logic                 trig,
    output logic                 busy,
    output logic [NUM_SLOTS-1:0] new_flags,
    output logic                 conv_start,
    output logic [CH_W-1:0]      conv_chan,
    output logic [REF_W-1:0]     conv_ref,
    output logic                 conv_diff,
    input  logic                 conv_done,
    input  logic [RES_W-1:0]     conv_result
);

    localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NUM_SLOTS);

    run_cfg_t         cfg_q;
    slot_entry_t      cur_entry;
    slot_t            ptr;
    slot_t            host_slot;
    logic             entry_we;
    logic             cfg_we;
    logic             res_rd_clr;
    logic             res_we;
    logic             clr_enable;
    logic [RES_W-1:0] rd_res;
    logic             rd_flag;

    assign host_slot  = reg_addr[SLOT_W-1:0];
    assign entry_we   = reg_we && !reg_addr[ADDR_W-1];
    assign cfg_we     = reg_we && (reg_addr == CFG_ADDR);
    assign res_rd_clr = reg_re && !reg_addr[ADDR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= run_cfg_t'(reg_wdata[CFG_W-1:0]);
        end else if (clr_enable) begin
            cfg_q.enable <= 1'b0;
        end
    end

    adcseq_entry_mem u_entries (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (entry_we),
        .wr_idx   (host_slot),
        .wr_entry (slot_entry_t'(reg_wdata[ENTRY_W-1:0])),
        .rd_idx   (ptr),
        .rd_entry (cur_entry)
    );

    adcseq_walker u_walker (
        .clk        (clk),
        .rst        (rst),
        .trig       (trig),
        .cfg        (cfg_q),
        .cur_last   (cur_entry.last),
        .conv_done  (conv_done),
        .ptr        (ptr),
        .conv_start (conv_start),
        .busy       (busy),
        .res_we     (res_we),
        .clr_enable (clr_enable)
    );

    adcseq_result_mem u_results (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (res_we),
        .wr_idx  (ptr),
        .wr_res  (conv_result),
        .rd_clr  (res_rd_clr),
        .rd_idx  (host_slot),
        .rd_res  (rd_res),
        .rd_flag (rd_flag),
        .flags   (new_flags)
    );

    assign conv_chan = cur_entry.chan;
    assign conv_ref  = cur_entry.refsel;
    assign conv_diff = cur_entry.diff;

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[ADDR_W-1]) begin
            if (reg_addr == CFG_ADDR) begin
                reg_rdata[CFG_W-1:0] = cfg_q;
            end
        end else begin
            reg_rdata[DATA_W-1]  = rd_flag;
            reg_rdata[RES_W-1:0] = rd_res;
        end
    end

    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (rst)
        (clr_enable && !cfg_we) |=> !cfg_q.enable); // R3

    AST_START_ARMED: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cfg_q.enable) |=> !busy); // R12

endmodule

// File: tb/adcseq_top_tb.sv
module adcseq_top_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we, reg_re;
    logic [5:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] reg_rdata;
    logic        trig;
    logic        busy;
    logic [31:0] new_flags;
    logic        conv_start;
    logic [4:0]  conv_chan;
    logic [1:0]  conv_ref;
    logic        conv_diff;
    logic        conv_done;
    logic [13:0] conv_result;

    always #10 clk = ~clk;

    adcseq_top u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .trig(trig), .busy(busy), .new_flags(new_flags),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_ref(conv_ref),
        .conv_diff(conv_diff), .conv_done(conv_done), .conv_result(conv_result)
    );

    typedef struct {
        int slot;
        bit last;
    } exp_item_t;

    exp_item_t   exp_q[$];
    logic [13:0] exp_res [32];
    int          n_checks = 0;
    int          n_errors = 0;
    int          conv_seen = 0;
    bit          coll_en = 0;
    int          coll_slot = 0;
    bit          finished = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] chan_of(input int s);
        return 5'(s) ^ 5'h0A;
    endfunction

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = 6'(a);
        #1 d = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    // entry layout: [8] last, [7] diff, [6:5] reference, [4:0] channel
    task automatic prog(input int s, input bit last);
        wr(s, {7'd0, last, 1'(s >> 2), 2'(s), chan_of(s)});
    endtask

    // config layout: [7] enable, [6:5] mode, [4:0] start
    task automatic set_cfg(input bit en, input int mode, input int start);
        wr(32, {8'd0, en, 2'(mode), 5'(start)});
    endtask

    task automatic push(input int s, input bit last);
        exp_item_t it;
        it.slot = s; it.last = last;
        exp_q.push_back(it);
    endtask

    task automatic pulse_trig;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic wait_idle(input string tag);
        int n = 0;
        while (busy && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " run ended"}, int'(busy), 0);
        chk({tag, " all expected conversions seen"}, exp_q.size(), 0);
    endtask

    task automatic chk_slot(input string tag, input int s, input bit flag);
        logic [15:0] d;
        rd(s, d);
        chk(tag, int'(d), int'({flag, 1'b0, exp_res[s]}));
    endtask

    task automatic chk_enable(input string tag, input bit en);
        logic [15:0] d;
        rd(32, d);
        chk(tag, int'(d[7]), int'(en));
    endtask

    // Converter model and scoreboard monitor
    initial begin
        int        cnt = 0;
        int        tag9 = 0;
        exp_item_t cur;
        bit        post = 0;
        bit        post_last = 0;
        bit        coll_rel = 0;
        logic [13:0] val;
        conv_done = 1'b0;
        conv_result = '0;
        cur.slot = 0; cur.last = 0;
        forever begin
            @(negedge clk);
            if (coll_rel) begin reg_re = 1'b0; coll_rel = 0; end
            if (post) begin
                chk(post_last ? "R11 busy falls after final done" : "R11 busy held between conversions",
                    int'(busy), post_last ? 0 : 1);
                post = 0;
            end
            conv_done = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    tag9++;
                    val = {chan_of(cur.slot), 9'(tag9)};
                    conv_result = val;
                    conv_done = 1'b1;
                    if (coll_en && cur.slot == coll_slot) begin
                        reg_re = 1'b1; reg_addr = 6'(cur.slot);
                        #1 chk("R10 same-cycle read returns old result", int'(reg_rdata),
                               int'({1'b1, 1'b0, exp_res[cur.slot]}));
                        coll_rel = 1; coll_en = 0;
                    end
                    exp_res[cur.slot] = val;
                    post = 1; post_last = cur.last;
                end
            end
            if (conv_start) begin
                conv_seen++;
                if (exp_q.size() == 0) begin
                    chk("R12 unexpected conversion started", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                    chk("R2 R5 channel of walked slot", int'(conv_chan), int'(chan_of(cur.slot)));
                    chk("R2 reference of slot", int'(conv_ref), cur.slot & 3);
                    chk("R2 differential of slot", int'(conv_diff), (cur.slot >> 2) & 1);
                    cnt = 2;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int base;
        for (int i = 0; i < 32; i++) exp_res[i] = '0;
        rst = 1'b1; reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0;
        reg_wdata = '0; trig = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", int'(busy), 0);
        chk("R1 conv_start after reset", int'(conv_start), 0);
        chk("R1 new flags after reset", int'(new_flags), 0);
        rd(32, d);
        chk("R1 config after reset", int'(d), 0);

        for (int i = 0; i < 32; i++) prog(i, 1'b0);

        // R3: one-shot single
        set_cfg(1, 0, 5);
        push(5, 1);
        pulse_trig();
        chk("R11 busy after accepted trigger", int'(busy), 1);
        wait_idle("R3");
        chk_enable("R3 enable cleared after one-shot", 0);
        chk_slot("R9 result with flag set", 5, 1);
        chk_slot("R9 flag cleared by read", 5, 0);

        // R12: trigger while disarmed
        base = conv_seen;
        pulse_trig();
        repeat (8) @(negedge clk);
        chk("R12 disarmed trigger keeps idle", int'(busy), 0);
        chk("R12 disarmed trigger starts nothing", conv_seen, base);

        // R4 and R10: repeating single with a same-cycle read
        set_cfg(1, 1, 7);
        push(7, 1);
        pulse_trig();
        wait_idle("R4 first");
        chk_enable("R4 enable kept", 1);
        push(7, 1);
        coll_en = 1; coll_slot = 7;
        pulse_trig();
        wait_idle("R4 second");
        chk_slot("R10 flag survives same-cycle read", 7, 1);
        chk_slot("R10 flag clears on later read", 7, 0);

        // R5, R6, R12: one-shot list wrapping past slot 31
        prog(2, 1'b1);
        set_cfg(1, 2, 29);
        push(29, 0); push(30, 0); push(31, 0); push(0, 0); push(1, 0); push(2, 1);
        pulse_trig();
        repeat (3) @(negedge clk);
        pulse_trig();
        wait_idle("R5 R6");
        chk_enable("R5 enable cleared after list", 0);
        chk_slot("R6 slot 31 result", 31, 1);
        chk_slot("R6 slot 0 after wrap", 0, 1);
        chk_slot("R5 slot past last untouched", 3, 0);

        // R7: repeating list
        prog(12, 1'b1);
        set_cfg(1, 3, 10);
        push(10, 0); push(11, 0); push(12, 1);
        pulse_trig();
        wait_idle("R7 first");
        push(10, 0); push(11, 0); push(12, 1);
        pulse_trig();
        wait_idle("R7 second");
        chk_enable("R7 enable kept", 1);
        chk_slot("R7 slot 12 rewritten", 12, 1);

        // R8: endless list stopped by disarming
        prog(2, 1'b0);
        prog(12, 1'b0);
        set_cfg(1, 2, 20);
        for (int i = 0; i < 35; i++) push((20 + i) % 32, i == 34);
        base = conv_seen;
        pulse_trig();
        wait (conv_seen == base + 35);
        set_cfg(0, 2, 20);
        wait_idle("R8");
        repeat (10) @(negedge clk);
        chk("R8 no conversion after disarm", conv_seen, base + 35);
        chk_slot("R8 final slot written", 22, 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule